// File: doc/BRIEF.md
# Dual-Clock Gray-Pointer FIFO

This block moves data words from one clock domain to another through a 512-entry inferred dual-port memory. Binary address counters index the memory directly. Each side also keeps Gray-coded copies of its pointer: the current value, the value after one more step, and, on the read side, the value one step behind. The write side's current Gray pointer and the read side's trailing Gray pointer each pass into the other domain through a two-flop synchronizer. Both flags are computed one cycle ahead from these copies and come straight out of flip-flops.

A producer drives `wr_en` with `wr_data` whenever `wr_full` is low. A consumer drives `rd_en` whenever `rd_empty` is low and takes `rd_data` after the next read-clock edge. Each domain has its own synchronous, active-high reset. A flag may stay set for a few cycles after the far side has moved. It never clears early.

Top module: `xclk_fifo`

## Requirements
- R1: Words leave on `rd_data` in the order they were accepted on `wr_data`, with no loss and no duplication, while the two clocks run at unrelated rates.
- R2: Starting from an empty FIFO with the read side idle, exactly 511 writes are accepted. `wr_full` is 1 on the write-clock edge that accepts the 511th word, so one slot always stays unused.
- R3: A write while `wr_full` is 1 is ignored. The word is never stored, the write pointer does not move, and `wr_full` stays 1.
- R4: A read while `rd_empty` is 1 is ignored. The read pointer does not move, `rd_data` keeps its value, and no word is consumed.
- R5: Both pointers wrap modulo 512. Each Gray pointer that crosses between domains changes at most one bit per clock. Ordering holds across more than two full wraps.
- R6: After reset, `rd_empty` is 1 and `wr_full` is 0. All pointers are zero, and the trailing read pointer is the Gray code of binary 511.
- R7: `rd_data` is registered. It takes the next word on the read-clock edge that accepts a read, and holds at all other times.
- R8: After a single write into an empty FIFO, `rd_empty` falls within the first six read-clock cycles.
- R9: With the FIFO full, `wr_full` falls within twelve write-clock cycles after reading starts.
- R10: Once the last stored word has been read and no write is in flight, `rd_empty` is 1 and stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-domain clock |
| wr_rst | input | 1 | Synchronous active-high reset, write domain |
| wr_en | input | 1 | Write request, ignored while full |
| wr_data | input | DW | Word to store |
| wr_full | output | 1 | Registered full flag |
| rd_clk | input | 1 | Read-domain clock |
| rd_rst | input | 1 | Synchronous active-high reset, read domain |
| rd_en | input | 1 | Read request, ignored while empty |
| rd_data | output | DW | Registered output word |
| rd_empty | output | 1 | Registered empty flag |

## Verification
The bench fills the FIFO with the reader halted and counts the accepted writes. A design whose full flag compares against the wrong pointer copy accepts 510 or 512 words, and 512 overwrites unread data. The bench then keeps driving writes of a marker word into the full FIFO and does reads against the empty FIFO. Honouring either request would show up as a foreign or missing word in the scoreboard, or as a changed `rd_data`. The bench also times how long each flag takes to release, which exposes a missing or extra synchronizer stage. Finally, it pushes throttled and full-rate traffic through several pointer wraps to catch wrong Gray lookahead values at the 511-to-0 boundary.

// File: rtl/xfifo_pkg.sv
package xfifo_pkg;
    localparam int unsigned XF_AW_DEF   = 9;
    localparam int unsigned XF_DW_DEF   = 16;
    localparam int unsigned XF_SYNC_LEN = 2;
endpackage

// File: rtl/xfifo_sync.sv
module xfifo_sync #(
    parameter int unsigned W = 9,
    parameter int unsigned STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < int'(STAGES); i++) stage[i] <= RST_VAL;
        end else begin
            stage[0] <= d;
            for (int i = 1; i < int'(STAGES); i++) stage[i] <= stage[i-1];
        end
    end

    assign q = stage[STAGES-1];
endmodule

// File: rtl/xfifo_ptr.sv
module xfifo_ptr #(
    parameter int unsigned AW = 9
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          adv,
    output logic [AW-1:0] bin,
    output logic [AW-1:0] cur_g,
    output logic [AW-1:0] nxt_g,
    output logic [AW-1:0] prv_g
);
    localparam logic [AW-1:0] ONE  = AW'(1);
    localparam logic [AW-1:0] TWO  = AW'(2);
    localparam logic [AW-1:0] ALL1 = {AW{1'b1}};

    function automatic logic [AW-1:0] to_gray(input logic [AW-1:0] b);
        return b ^ (b >> 1);
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            bin   <= '0;
            cur_g <= '0;
            nxt_g <= to_gray(ONE);
            prv_g <= to_gray(ALL1);
        end else if (adv) begin
            bin   <= bin + ONE;
            prv_g <= cur_g;
            cur_g <= nxt_g;
            nxt_g <= to_gray(bin + TWO);
        end
    end
endmodule

// File: rtl/xfifo_ram.sv
module xfifo_ram #(
    parameter int unsigned AW = 9,
    parameter int unsigned DW = 16
) (
    input  logic          wclk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic          rclk,
    input  logic          rrst,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int unsigned DEPTH = 1 << AW;

    logic [DW-1:0] store [DEPTH];

    always_ff @(posedge wclk) begin
        if (we) store[waddr] <= wdata;
    end

    always_ff @(posedge rclk) begin
        if (rrst)    rdata <= '0;
        else if (re) rdata <= store[raddr];
    end
endmodule

// File: rtl/xclk_fifo.sv
module xclk_fifo
    import xfifo_pkg::*;
#(
    parameter int unsigned AW = XF_AW_DEF,
    parameter int unsigned DW = XF_DW_DEF
) (
    input  logic          wr_clk,
    input  logic          wr_rst,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    output logic          wr_full,
    input  logic          rd_clk,
    input  logic          rd_rst,
    input  logic          rd_en,
    output logic [DW-1:0] rd_data,
    output logic          rd_empty
);
    localparam logic [AW-1:0] ALL1     = {AW{1'b1}};
    localparam logic [AW-1:0] PRV_INIT = ALL1 ^ (ALL1 >> 1);

    logic          push, pop;
    logic [AW-1:0] w_bin, w_cur_g, w_nxt_g, w_prv_g;
    logic [AW-1:0] r_bin, r_cur_g, r_nxt_g, r_prv_g;
    logic [AW-1:0] w_seen_rprv;
    logic [AW-1:0] r_seen_wcur;
    logic [AW-1:0] w_look_g, r_look_g;

    assign push = wr_en & ~wr_full;
    assign pop  = rd_en & ~rd_empty;

    xfifo_ptr #(.AW(AW)) u_wptr (
        .clk(wr_clk), .rst(wr_rst), .adv(push),
        .bin(w_bin), .cur_g(w_cur_g), .nxt_g(w_nxt_g), .prv_g(w_prv_g)
    );

    xfifo_ptr #(.AW(AW)) u_rptr (
        .clk(rd_clk), .rst(rd_rst), .adv(pop),
        .bin(r_bin), .cur_g(r_cur_g), .nxt_g(r_nxt_g), .prv_g(r_prv_g)
    );

    // trailing read pointer into the write domain
    xfifo_sync #(.W(AW), .STAGES(XF_SYNC_LEN), .RST_VAL(PRV_INIT)) u_r2w (
        .clk(wr_clk), .rst(wr_rst), .d(r_prv_g), .q(w_seen_rprv)
    );

    // current write pointer into the read domain
    xfifo_sync #(.W(AW), .STAGES(XF_SYNC_LEN), .RST_VAL('0)) u_w2r (
        .clk(rd_clk), .rst(rd_rst), .d(w_cur_g), .q(r_seen_wcur)
    );

    // pointer value in effect after this edge, taken from the registered copies
    assign w_look_g = push ? w_nxt_g : w_cur_g;
    assign r_look_g = pop  ? r_nxt_g : r_cur_g;

    always_ff @(posedge wr_clk) begin
        if (wr_rst) wr_full <= 1'b0;
        else        wr_full <= (w_look_g == w_seen_rprv);
    end

    always_ff @(posedge rd_clk) begin
        if (rd_rst) rd_empty <= 1'b1;
        else        rd_empty <= (r_look_g == r_seen_wcur);
    end

    xfifo_ram #(.AW(AW), .DW(DW)) u_ram (
        .wclk(wr_clk), .we(push), .waddr(w_bin), .wdata(wr_data),
        .rclk(rd_clk), .rrst(rd_rst), .re(pop), .raddr(r_bin), .rdata(rd_data)
    );
endmodule

// File: rtl/xclk_fifo_chk.sv
module xclk_fifo_chk #(
    parameter int unsigned AW = 9
) (
    input logic          wr_clk,
    input logic          wr_rst,
    input logic          wr_en,
    input logic          wr_full,
    input logic          rd_clk,
    input logic          rd_rst,
    input logic          rd_en,
    input logic          rd_empty,
    input logic [AW-1:0] w_bin,
    input logic [AW-1:0] r_bin,
    input logic [AW-1:0] w_cur_g,
    input logic [AW-1:0] r_cur_g,
    input logic [AW-1:0] r_prv_g
);
    // R3: a refused write leaves the write address where it was
    a_r3_no_overflow: assert property (@(posedge wr_clk) disable iff (wr_rst)
        (wr_en && wr_full) |=> $stable(w_bin));

    // R4: a refused read leaves the read address where it was
    a_r4_no_underflow: assert property (@(posedge rd_clk) disable iff (rd_rst)
        (rd_en && rd_empty) |=> $stable(r_bin));

    // R5: crossing pointers move by one Gray step at most
    a_r5_wgray_step: assert property (@(posedge wr_clk) disable iff (wr_rst)
        $countones(w_cur_g ^ $past(w_cur_g)) <= 1);

    a_r5_rgray_step: assert property (@(posedge rd_clk) disable iff (rd_rst)
        $countones(r_cur_g ^ $past(r_cur_g)) <= 1);

    a_r5_rprev_step: assert property (@(posedge rd_clk) disable iff (rd_rst)
        $countones(r_prv_g ^ $past(r_prv_g)) <= 1);

    // R6: flags leave reset in their idle state
    a_r6_empty_out_of_reset: assert property (@(posedge rd_clk) disable iff (rd_rst)
        $past(rd_rst) |-> rd_empty);

    a_r6_full_out_of_reset: assert property (@(posedge wr_clk) disable iff (wr_rst)
        $past(wr_rst) |-> !wr_full);
endmodule

bind xclk_fifo xclk_fifo_chk #(.AW(AW)) u_chk (
    .wr_clk(wr_clk), .wr_rst(wr_rst), .wr_en(wr_en), .wr_full(wr_full),
    .rd_clk(rd_clk), .rd_rst(rd_rst), .rd_en(rd_en), .rd_empty(rd_empty),
    .w_bin(w_bin), .r_bin(r_bin), .w_cur_g(w_cur_g), .r_cur_g(r_cur_g),
    .r_prv_g(r_prv_g)
);

// File: tb/tb_xclk_fifo.sv
module tb_xclk_fifo;
    localparam int DW = 16;
    localparam logic [DW-1:0] JUNK = 16'hDEAD;

    logic          wr_clk = 0, rd_clk = 0;
    logic          wr_rst = 1, rd_rst = 1;
    logic          wr_en = 0, rd_en = 0;
    logic [DW-1:0] wr_data = '0;
    logic [DW-1:0] rd_data;
    logic          wr_full, rd_empty;

    int n_chk = 0, n_bad = 0;
    logic [DW-1:0] q [$];
    logic [DW-1:0] next_val = 16'h0100;
    bit reader_on = 0, force_rd = 0, rd_throttle = 0;
    int total_written = 0;

    always #2.5  wr_clk = ~wr_clk;   // 200 MHz
    always #3.65 rd_clk = ~rd_clk;

    xclk_fifo #(.AW(9), .DW(DW)) dut (
        .wr_clk(wr_clk), .wr_rst(wr_rst), .wr_en(wr_en), .wr_data(wr_data), .wr_full(wr_full),
        .rd_clk(rd_clk), .rd_rst(rd_rst), .rd_en(rd_en), .rd_data(rd_data), .rd_empty(rd_empty)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    endtask

    // monitor: compares each word one read-clock later (R7 registered output)
    initial begin
        bit pend = 0;
        bit go;
        logic [15:0] lf = 16'hACE1;
        logic [DW-1:0] exp;
        forever begin
            @(negedge rd_clk);
            if (pend) begin
                if (q.size() == 0) begin
                    check(0, "R4 word emitted with nothing stored", 32'(rd_data), 0);
                end else begin
                    exp = q.pop_front();
                    check(rd_data == exp, "R1 R7 order/registered read", 32'(rd_data), 32'(exp));
                end
            end
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            go = !rd_throttle || lf[0];
            pend = reader_on && go && !rd_empty;
            rd_en = reader_on && (force_rd || (go && !rd_empty));
        end
    end

    task automatic wr_burst(input int n, input bit gaps);
        int sent = 0;
        logic [15:0] lf = 16'h1D0B;
        while (sent < n) begin
            @(negedge wr_clk);
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            if ((gaps && lf[0]) || wr_full) begin
                wr_en = 0;
            end else begin
                wr_en = 1;
                wr_data = next_val;
                q.push_back(next_val);
                next_val++;
                sent++;
                total_written++;
            end
        end
        @(negedge wr_clk);
        wr_en = 0;
    endtask

    task automatic drain();
        int guard = 0;
        while (q.size() != 0 && guard < 20000) begin
            @(negedge rd_clk);
            guard++;
        end
        repeat (8) @(negedge rd_clk);
        check(q.size() == 0, "R10 all stored words delivered", q.size(), 0);
        check(rd_empty == 1, "R10 empty after last word", 32'(rd_empty), 1);
    endtask

    initial begin
        repeat (150000) @(posedge wr_clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        int cnt;
        logic [DW-1:0] held;
        int bad_before;

        repeat (6) @(negedge rd_clk);
        wr_rst = 0;
        rd_rst = 0;
        @(negedge wr_clk);
        @(negedge rd_clk);
        check(rd_empty == 1, "R6 empty after reset", 32'(rd_empty), 1);
        check(wr_full == 0, "R6 full clear after reset", 32'(wr_full), 0);

        // R8: single word, measure release of empty
        repeat (10) @(negedge rd_clk);
        wr_burst(1, 0);
        cnt = 0;
        while (rd_empty && cnt < 20) begin
            @(negedge rd_clk);
            cnt++;
        end
        check(cnt <= 6, "R8 empty release latency", cnt, 6);
        reader_on = 1;
        drain();

        // R4: reads against an empty FIFO
        held = rd_data;
        force_rd = 1;
        repeat (10) begin
            @(negedge rd_clk);
            check(rd_empty == 1, "R4 empty holds under reads", 32'(rd_empty), 1);
        end
        force_rd = 0;
        @(negedge rd_clk);
        check(rd_data == held, "R4 R7 rd_data holds on refused read", 32'(rd_data), 32'(held));
        wr_burst(3, 0);
        drain();

        // R2: fill with reader halted
        reader_on = 0;
        repeat (10) @(negedge wr_clk);
        cnt = 0;
        while (cnt < 1000) begin
            @(negedge wr_clk);
            if (wr_full) break;
            wr_en = 1;
            wr_data = next_val;
            q.push_back(next_val);
            next_val++;
            total_written++;
            cnt++;
        end
        wr_en = 0;
        check(cnt == 511, "R2 accepted words before full", cnt, 511);

        // R3: writes into a full FIFO
        repeat (6) begin
            @(negedge wr_clk);
            wr_en = 1;
            wr_data = JUNK;
            check(wr_full == 1, "R3 full holds under writes", 32'(wr_full), 1);
        end
        @(negedge wr_clk);
        wr_en = 0;
        check(wr_full == 1, "R3 full still set", 32'(wr_full), 1);

        // R9: release of full once reading starts
        reader_on = 1;
        cnt = 0;
        while (wr_full && cnt < 40) begin
            @(negedge wr_clk);
            cnt++;
        end
        check(cnt <= 12, "R9 full release latency", cnt, 12);
        drain();

        // R5: wrap the pointers under throttled and full-rate traffic
        bad_before = n_bad;
        rd_throttle = 1;
        wr_burst(700, 1);
        drain();
        rd_throttle = 0;
        wr_burst(700, 0);
        drain();
        check(total_written > 1024, "R5 traffic crossed pointer wraps", total_written, 1025);
        check(n_bad == bad_before, "R5 order kept across wraps", n_bad - bad_before, 0);

        finish_run();
    end
endmodule